// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This controller sits between a clocked request port and a 16-Mbit asynchronous static RAM. The RAM can be used as 1M words of 16 bits or 2M bytes. Each request carries an address, write data, two byte enables, a write flag and a mode flag. The controller accepts one request at a time on a valid/ready handshake. It then drives the RAM's two chip selects (one active low, one active high), its output enable, its write strobe and its two byte-lane strobes. The pin timing is derived from nanosecond limits that are rounded up to whole clock cycles.

Reads return the sampled data with a single-cycle response pulse. The data-bus direction is exposed as a separate output value plus an output-enable. The controller asserts that enable only inside the write strobe window. It first waits for the RAM to release the bus.

The mode flag is sampled with each request. In 16-bit mode the low 20 address bits form the word address and each byte enable gates its own lane. In 8-bit mode the 21-bit byte address is split into a 20-bit word address and one extra lowest address bit. In that mode data travels on the low lane only.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset, and whenever no access is in progress, the RAM is deselected (`sram_ce1_n`=1, `sram_ce2`=0). During an access both selects are active together (`sram_ce1_n`=0, `sram_ce2`=1). Reset also leaves `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0 and `rsp_valid`=0.
- R2: Every access keeps the chip selected with an unchanging `sram_addr` for at least ceil(T_RC_NS/CLK_NS) cycles (6 at the defaults).
- R3: A read drives `sram_oe_n` low and samples the bus after max(ceil(T_ACC_NS/CLK_NS), ceil(T_OE_NS/CLK_NS), ceil(T_RC_NS/CLK_NS)) cycles (6 at the defaults). `rsp_valid` pulses for one cycle exactly that many cycles after the accepting edge, carrying the data in `rsp_rdata`.
- R4: A write holds `sram_we_n` low for max(ceil(T_WP_NS/CLK_NS), ceil(T_CW_NS/CLK_NS), ceil(T_HZ_NS/CLK_NS)+ceil(T_DS_NS/CLK_NS)) cycles (6 at the defaults), with the chip selected for that whole window.
- R5: Write data is driven (`sram_dq_oe`=1) starting ceil(T_HZ_NS/CLK_NS) cycles after `sram_we_n` falls (3 at the defaults). It is held stable for at least ceil(T_DS_NS/CLK_NS) cycles (3) and released on the same edge that raises `sram_we_n`.
- R6: `sram_dq_oe` is never 1 while `sram_oe_n` is 0, and `sram_oe_n` and `sram_we_n` are never low together, so the bus never has two drivers.
- R7: In 16-bit mode (`req_byte_mode`=0), `sram_lb_n`=!`req_be[0]` gates bits 7:0 and `sram_ub_n`=!`req_be[1]` gates bits 15:8 for reads and writes. A read returns 0 in any lane whose enable is 0.
- R8: In 16-bit mode, `sram_byte_n`=1, `sram_addr`=`req_addr[19:0]` and `sram_a_lsb`=0. In 8-bit mode, `sram_byte_n`=0, `sram_addr`=`req_addr[20:1]`, `sram_a_lsb`=`req_addr[0]`, `sram_lb_n`=0 and `sram_ub_n`=1, and `req_be` is ignored. Writes drive `req_wdata[7:0]` on bits 7:0, and reads return the byte in `rsp_rdata[7:0]` with bits 15:8 zero.
- R9: `req_ready` is 1 only while idle. A request is taken on an edge where `req_valid` and `req_ready` are both 1, and `req_ready` returns to 1 on the edge that ends the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this edge |
| req_write | input | 1 | 1 write, 0 read |
| req_byte_mode | input | 1 | 1 selects 8-bit mode for this request |
| req_addr | input | 21 | Word address (bits 19:0) or byte address (bits 20:0) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables in 16-bit mode |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data |
| sram_addr | output | 20 | RAM address |
| sram_a_lsb | output | 1 | Extra lowest address bit in 8-bit mode |
| sram_ce1_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_lb_n | output | 1 | Active-low low-lane strobe |
| sram_ub_n | output | 1 | Active-low high-lane strobe |
| sram_byte_n | output | 1 | Active-low 8-bit mode select |
| sram_dq_out | output | 16 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Bus direction: 1 drives sram_dq_out |
| sram_dq_in | input | 16 | Data from the RAM |

## Verification
The bench's RAM model returns a poison word until the access time has passed. A controller that samples a read too early therefore returns that word and fails the scoreboard. The model also flags a write strobe shorter than the pulse limit, write data driven for too few cycles, and contention with its own read drive; a shortened strobe or an early bus turn-on shows up as a flag. Random traffic mixes both modes, both address halves in 8-bit mode and all four lane masks, and interleaves reads right after writes. A wrong lane strobe, a mis-split byte address or an unmasked disabled lane then reads back as the wrong value.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 55,
  parameter int T_ACC_NS = 55,
  parameter int T_OE_NS  = 30,
  parameter int T_WP_NS  = 40,
  parameter int T_CW_NS  = 45,
  parameter int T_DS_NS  = 25,
  parameter int T_HZ_NS  = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_byte_mode,
  input  logic [20:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic [1:0]  req_be,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic [19:0] sram_addr,
  output logic        sram_a_lsb,
  output logic        sram_ce1_n,
  output logic        sram_ce2,
  output logic        sram_oe_n,
  output logic        sram_we_n,
  output logic        sram_lb_n,
  output logic        sram_ub_n,
  output logic        sram_byte_n,
  output logic [15:0] sram_dq_out,
  output logic        sram_dq_oe,
  input  logic [15:0] sram_dq_in
);
  localparam int C_RC  = (T_RC_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_ACC = (T_ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_OE  = (T_OE_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_WP  = (T_WP_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_CW  = (T_CW_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_DS  = (T_DS_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_HZ  = (T_HZ_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_SMP = (C_ACC > C_OE) ? C_ACC : C_OE;
  localparam int RD_LEN = (C_SMP > C_RC) ? C_SMP : C_RC;
  localparam int C_WPC = (C_WP > C_CW) ? C_WP : C_CW;
  localparam int WR_LO = (C_WPC > C_HZ + C_DS) ? C_WPC : C_HZ + C_DS;
  localparam int WR_LEN = (WR_LO > C_RC) ? WR_LO : C_RC;
  localparam int CW = $clog2(WR_LEN + RD_LEN + 1);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_LEN - 1);
  localparam logic [CW-1:0] WR_RISE = CW'(WR_LO - 1);
  localparam logic [CW-1:0] WR_LAST = CW'(WR_LEN - 1);
  localparam logic [CW-1:0] DQ_ON   = CW'(C_HZ - 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic sel;

  assign req_ready  = (st == S_IDLE);
  assign sram_ce1_n = !sel;
  assign sram_ce2   = sel;

  wire        take      = req_valid && req_ready;
  wire [15:0] lane_mask = {{8{!sram_ub_n}}, {8{!sram_lb_n}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      sel <= 1'b0;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_dq_oe <= 1'b0;
      sram_dq_out <= '0;
      sram_addr <= '0;
      sram_a_lsb <= 1'b0;
      sram_lb_n <= 1'b1;
      sram_ub_n <= 1'b1;
      sram_byte_n <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          sel <= 1'b1;
          cnt <= '0;
          sram_byte_n <= !req_byte_mode;
          if (req_byte_mode) begin
            sram_addr <= req_addr[20:1];
            sram_a_lsb <= req_addr[0];
            sram_lb_n <= 1'b0;
            sram_ub_n <= 1'b1;
            sram_dq_out <= {8'h00, req_wdata[7:0]};
          end else begin
            sram_addr <= req_addr[19:0];
            sram_a_lsb <= 1'b0;
            sram_lb_n <= !req_be[0];
            sram_ub_n <= !req_be[1];
            sram_dq_out <= req_wdata;
          end
          if (req_write) begin
            sram_we_n <= 1'b0;
            st <= S_WR;
          end else begin
            sram_oe_n <= 1'b0;
            st <= S_RD;
          end
        end
        S_RD: begin
          cnt <= cnt + 1'b1;
          if (cnt == RD_LAST) begin
            rsp_rdata <= sram_dq_in & lane_mask;
            rsp_valid <= 1'b1;
            sram_oe_n <= 1'b1;
            sel <= 1'b0;
            st <= S_IDLE;
          end
        end
        S_WR: begin
          cnt <= cnt + 1'b1;
          if (cnt == DQ_ON) sram_dq_oe <= 1'b1;
          if (cnt == WR_RISE) begin
            sram_we_n <= 1'b1;
            sram_dq_oe <= 1'b0;
          end
          if (cnt == WR_LAST) begin
            sel <= 1'b0;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sram_ctrl_chk #(
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 55,
  parameter int T_ACC_NS = 55,
  parameter int T_OE_NS  = 30,
  parameter int T_WP_NS  = 40,
  parameter int T_CW_NS  = 45,
  parameter int T_DS_NS  = 25,
  parameter int T_HZ_NS  = 25
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic [19:0] sram_addr,
  input logic        sram_ce1_n,
  input logic        sram_ce2,
  input logic        sram_oe_n,
  input logic        sram_we_n,
  input logic [15:0] sram_dq_out,
  input logic        sram_dq_oe
);
  localparam int C_RC  = (T_RC_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_ACC = (T_ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_OE  = (T_OE_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_WP  = (T_WP_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_CW  = (T_CW_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_DS  = (T_DS_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_HZ  = (T_HZ_NS  + CLK_NS - 1) / CLK_NS;

  logic [7:0] n_sel, n_we, n_oe, n_dq;
  wire selected = !sram_ce1_n && sram_ce2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_sel <= '0; n_we <= '0; n_oe <= '0; n_dq <= '0;
    end else begin
      n_sel <= !selected ? 8'd0 : (n_sel == 8'hFF ? n_sel : n_sel + 8'd1);
      n_we  <= sram_we_n ? 8'd0 : (n_we == 8'hFF ? n_we : n_we + 8'd1);
      n_oe  <= sram_oe_n ? 8'd0 : (n_oe == 8'hFF ? n_oe : n_oe + 8'd1);
      n_dq  <= !sram_dq_oe ? 8'd0 : (n_dq == 8'hFF ? n_dq : n_dq + 8'd1);
    end
  end

  p_sel_polarity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_ce1_n == !sram_ce2) && (req_ready == !selected));
  p_cycle_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_ce2) |-> n_sel >= 8'(C_RC));
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    selected && $past(selected) |-> $stable(sram_addr));
  p_read_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (n_oe >= 8'(C_ACC)) && (n_oe >= 8'(C_OE)));
  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (n_we >= 8'(C_WP)) && (n_sel > 8'(C_CW)));
  p_bus_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> !sram_we_n && n_we >= 8'(C_HZ));
  p_data_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> n_dq >= 8'(C_DS));
  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe && $past(sram_dq_oe) |-> $stable(sram_dq_out));
  p_no_fight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_dq_oe && !sram_oe_n) && (sram_oe_n || sram_we_n));
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .CLK_NS(CLK_NS), .T_RC_NS(T_RC_NS), .T_ACC_NS(T_ACC_NS), .T_OE_NS(T_OE_NS),
  .T_WP_NS(T_WP_NS), .T_CW_NS(T_CW_NS), .T_DS_NS(T_DS_NS), .T_HZ_NS(T_HZ_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
  .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out),
  .sram_dq_oe(sram_dq_oe)
);

// File: tb/sim_sram_ctrl.sv
module sram_stub #(
  parameter int ACC_CYC = 6,
  parameter int WP_CYC  = 4,
  parameter int DS_CYC  = 3
) (
  input  logic        clk,
  input  logic [19:0] addr,
  input  logic        a_lsb,
  input  logic        ce1_n,
  input  logic        ce2,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic        lb_n,
  input  logic        ub_n,
  input  logic        byte_n,
  input  logic [15:0] dq_from_ctrl,
  input  logic        dq_oe,
  output logic [15:0] dq_to_ctrl,
  output logic        viol
);
  logic [15:0] mem [256];
  logic [15:0] wlat;
  int rd_cnt = 0, we_cnt = 0, ds_cnt = 0;
  wire sel = !ce1_n && ce2;
  wire drv = sel && !oe_n && we_n;
  wire [7:0] w = addr[7:0];
  wire [7:0] half = a_lsb ? mem[w][15:8] : mem[w][7:0];

  initial begin
    viol = 1'b0;
    wlat = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
  end

  always_comb begin
    if (!drv) dq_to_ctrl = 16'h0000;
    else if (rd_cnt < ACC_CYC - 1) dq_to_ctrl = 16'h0BAD;
    else if (!byte_n) dq_to_ctrl = {8'hA5, half};
    else dq_to_ctrl = {ub_n ? 8'hA5 : mem[w][15:8], lb_n ? 8'hA5 : mem[w][7:0]};
  end

  always @(posedge clk) begin
    rd_cnt <= drv ? rd_cnt + 1 : 0;
    we_cnt <= (sel && !we_n) ? we_cnt + 1 : 0;
    ds_cnt <= dq_oe ? ds_cnt + 1 : 0;
    if (dq_oe && !oe_n) viol <= 1'b1;
    if (dq_oe && !we_n) wlat <= dq_from_ctrl;
    if (we_n && we_cnt != 0) begin
      if (we_cnt < WP_CYC || ds_cnt < DS_CYC) viol <= 1'b1;
      if (!byte_n) begin
        if (a_lsb) mem[w][15:8] <= wlat[7:0];
        else mem[w][7:0] <= wlat[7:0];
      end else begin
        if (!lb_n) mem[w][7:0] <= wlat[7:0];
        if (!ub_n) mem[w][15:8] <= wlat[15:8];
      end
    end
  end
endmodule

module sim_sram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RD_CYC = 6;
  localparam int WR_CYC = 6;
  localparam int HZ_CYC = 3;
  localparam int DS_CYC = 3;
  localparam int RC_CYC = 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_byte_mode = 0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [19:0] sram_addr;
  logic sram_a_lsb, sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n;
  logic sram_lb_n, sram_ub_n, sram_byte_n, sram_dq_oe, viol;
  logic [15:0] sram_dq_out, sram_dq_in;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_byte_mode(req_byte_mode), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .sram_addr(sram_addr), .sram_a_lsb(sram_a_lsb),
    .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
    .sram_byte_n(sram_byte_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  sram_stub u_mem (
    .clk(clk), .addr(sram_addr), .a_lsb(sram_a_lsb), .ce1_n(sram_ce1_n),
    .ce2(sram_ce2), .oe_n(sram_oe_n), .we_n(sram_we_n), .lb_n(sram_lb_n),
    .ub_n(sram_ub_n), .byte_n(sram_byte_n), .dq_from_ctrl(sram_dq_out),
    .dq_oe(sram_dq_oe), .dq_to_ctrl(sram_dq_in), .viol(viol)
  );

  int total = 0, bad = 0, cyc = 0, n_reads = 0, n_rsp = 0;
  bit done = 0;
  logic [15:0] mdl [256];
  logic [15:0] exp_q[$];
  int lat_q[$];
  int wl_run = 0, wlen = 0, hzgap = -1, dq_run = 0, dlen = 0;
  bit dq_seen = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!sram_we_n) wl_run++;
    else if (wl_run != 0) begin wlen = wl_run; wl_run = 0; dq_seen = 0; end
    if (sram_dq_oe) begin
      if (!dq_seen) begin hzgap = wl_run - 1; dq_seen = 1; end
      dq_run++;
    end else if (dq_run != 0) begin dlen = dq_run; dq_run = 0; end
    if (rsp_valid) begin
      n_rsp++;
      if (exp_q.size() == 0) chk(0, "R3 unexpected response", 32'(rsp_rdata), 0);
      else begin
        logic [15:0] e;
        int a;
        e = exp_q.pop_front();
        a = lat_q.pop_front();
        chk(rsp_rdata == e, "R3/R7/R8 read data", 32'(rsp_rdata), 32'(e));
        chk(cyc - a == RD_CYC, "R3 read latency", 32'(cyc - a), 32'(RD_CYC));
      end
    end
  end

  task automatic issue(input bit wr, input bit bm, input logic [20:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [19:0] ea;
    int selcnt, acc;
    bit abad;
    logic [7:0] wi;
    ea = bm ? a[20:1] : a[19:0];
    wi = bm ? a[8:1] : a[7:0];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_byte_mode = bm;
    req_addr = a; req_wdata = d; req_be = be;
    if (wr) begin
      if (bm) begin
        if (a[0]) mdl[wi][15:8] = d[7:0]; else mdl[wi][7:0] = d[7:0];
      end else begin
        if (be[0]) mdl[wi][7:0] = d[7:0];
        if (be[1]) mdl[wi][15:8] = d[15:8];
      end
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    acc = cyc;
    if (!wr) begin
      n_reads++;
      if (bm) exp_q.push_back({8'h00, a[0] ? mdl[wi][15:8] : mdl[wi][7:0]});
      else exp_q.push_back(mdl[wi] & {{8{be[1]}}, {8{be[0]}}});
      lat_q.push_back(acc);
    end
    chk(!req_ready, "R9 ready low while busy", 32'(req_ready), 0);
    chk(!sram_ce1_n && sram_ce2, "R1 selects active", {sram_ce1_n, sram_ce2}, 32'b01);
    chk(sram_byte_n == !bm && sram_a_lsb == (bm & a[0]), "R8 mode pins",
        {sram_byte_n, sram_a_lsb}, {!bm, bm & a[0]});
    if (bm) chk(!sram_lb_n && sram_ub_n, "R8 lane strobes in byte mode",
                {sram_lb_n, sram_ub_n}, 32'b01);
    else chk(sram_lb_n == !be[0] && sram_ub_n == !be[1], "R7 lane strobes",
             {sram_lb_n, sram_ub_n}, {!be[0], !be[1]});
    selcnt = 0; abad = 0;
    while (!req_ready) begin
      if (!sram_ce1_n && sram_ce2) begin
        selcnt++;
        if (sram_addr != ea) abad = 1;
      end
      @(negedge clk);
    end
    chk(selcnt >= RC_CYC && !abad, "R2 select length and address hold",
        32'(selcnt), 32'(RC_CYC));
    chk(sram_ce1_n && !sram_ce2, "R1 deselected when idle", {sram_ce1_n, sram_ce2}, 32'b10);
    if (wr) begin
      @(negedge clk);
      chk(wlen == WR_CYC, "R4 write strobe width", 32'(wlen), 32'(WR_CYC));
      chk(hzgap == HZ_CYC, "R5 bus turn-on delay", 32'(hzgap), 32'(HZ_CYC));
      chk(dlen == WR_CYC - HZ_CYC && dlen >= DS_CYC, "R5 data drive length",
          32'(dlen), 32'(WR_CYC - HZ_CYC));
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk(sram_ce1_n && !sram_ce2, "R1 reset deselect", {sram_ce1_n, sram_ce2}, 32'b10);
    chk(sram_oe_n && sram_we_n && !sram_dq_oe && !rsp_valid, "R1 reset strobes",
        {sram_oe_n, sram_we_n, sram_dq_oe, rsp_valid}, 32'b1100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R9 ready after reset", 32'(req_ready), 1);

    issue(1, 0, 21'h1_2305, 16'h1234, 2'b11);
    issue(0, 0, 21'h0_0005, 16'h0000, 2'b11);
    issue(1, 0, 21'h0_0005, 16'hAB99, 2'b10);
    issue(0, 0, 21'h0_0005, 16'h0000, 2'b11);
    issue(0, 0, 21'h0_0005, 16'h0000, 2'b01);
    issue(0, 0, 21'h0_0005, 16'h0000, 2'b00);
    issue(1, 1, 21'h0_000B, 16'hFF77, 2'b00);
    issue(1, 1, 21'h0_000A, 16'h0066, 2'b00);
    issue(0, 1, 21'h0_000B, 16'h0000, 2'b00);
    issue(0, 0, 21'h0_0005, 16'h0000, 2'b11);
    for (int k = 0; k < 400; k++) begin
      bit wr, bm;
      logic [20:0] a;
      wr = 1'($urandom);
      bm = 1'($urandom);
      a = 21'($urandom);
      issue(wr, bm, a, 16'($urandom), 2'($urandom));
    end
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0 && n_rsp == n_reads, "R3 every read answered",
        32'(n_rsp), 32'(n_reads));
    chk(!viol, "R6 memory model saw no timing or bus violation", 32'(viol), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule